// File: doc/BRIEF.md
# Binned Dot-Product Engine

This block forms a dot product for network layers whose weights are stored as short bin indices into a small table of shared weight values. Each input beat carries a signed activation and the bin index of its weight. While beats stream in, the activation is added into the accumulator owned by that bin. This path has index-driven selection and adders but no multiplier.

A beat flagged as last closes the stream. The engine then visits every bin in turn, one per cycle. It multiplies each bin total by the bin's shared weight on one common multiplier and sums the products. When the final bin has been added, the result appears together with a one-cycle completion pulse. The shared weight table is written through a simple address/data/enable port between dot products.

Top module: `binned_mac`

## Requirements
- R1: After reset `in_ready` is 1, `res_done` is 0 and `res_data` is 0.
- R2: Every accepted beat (`in_valid` and `in_ready` both 1) adds the sign-extended 8-bit `in_act` into the 24-bit accumulator of bin `in_idx` (4 bits, 16 bins), using selection and adders only.
- R3: An accepted beat with `in_start` set clears all 16 bin accumulators before its own activation is added, so beats before it do not count.
- R4: An accepted beat with `in_last` set ends the accumulation phase. `in_ready` is 0 from the next cycle until the cycle in which `res_done` is 1.
- R5: The multiply phase takes bins 0 to 15 in order, one per cycle, through a single shared multiplier. `res_done` and the new `res_data` appear at the 16th rising edge after the edge that accepted the last beat.
- R6: `res_done` is high for exactly one cycle. `res_data` changes only in a cycle where `res_done` is 1 and holds its value otherwise.
- R7: A write with `wt_we` = 1 stores the signed 8-bit `wt_data` as the weight of bin `wt_addr` only while `in_ready` is 1. A write during the multiply phase is ignored.
- R8: A bin that received no beat adds zero. `res_data` (signed 32-bit) equals the direct sum of activation times weight over the beats since the start.
- R9: All shared weights reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Engine accepts beats (accumulation phase) |
| in_act | input | 8 | Signed activation |
| in_idx | input | 4 | Bin index of the activation's weight |
| in_start | input | 1 | Beat begins a new dot product |
| in_last | input | 1 | Beat ends the dot product |
| wt_we | input | 1 | Shared weight write enable |
| wt_addr | input | 4 | Bin whose weight is written |
| wt_data | input | 8 | Signed shared weight value |
| res_data | output | 32 | Signed dot-product result |
| res_done | output | 1 | One-cycle completion pulse |

## Verification
The bin accumulators change at the same edge that accepts a beat. The result is due exactly sixteen rising edges after the edge that takes the last beat. The bench samples on falling edges and counts the falling edges after that acceptance. It expects `res_done` on the seventeenth of them, checks `in_ready` low on each earlier one, and checks `res_done` low again on the next one. Expected sums are computed in the bench as plain activation-times-weight arithmetic over sweeps of every bin against boundary activations, long mixed streams, restarts and extreme weights.

// File: rtl/binned_mac_pkg.sv
package binned_mac_pkg;
   typedef enum logic {
      PH_ACC = 1'b0,
      PH_MUL = 1'b1
   } phase_t;
endpackage

// File: rtl/bin_weight_table.sv
module bin_weight_table #(
   parameter int NUM_BINS = 16,
   parameter int WGT_W    = 8,
   localparam int IDX_W   = $clog2(NUM_BINS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic signed [WGT_W-1:0] wr_val,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic signed [WGT_W-1:0] rd_val
);
   logic signed [WGT_W-1:0] wgt_q [NUM_BINS];

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wgt_q[b] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(b)))
            wgt_q[b] <= wr_val;
      end
   end

   assign rd_val = wgt_q[rd_idx];
endmodule

// File: rtl/bin_accum_bank.sv
module bin_accum_bank #(
   parameter int NUM_BINS = 16,
   parameter int ACT_W    = 8,
   parameter int ACC_W    = 24,
   localparam int IDX_W   = $clog2(NUM_BINS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    add_en,
   input  logic                    clr,
   input  logic [IDX_W-1:0]        add_idx,
   input  logic signed [ACT_W-1:0] add_act,
   input  logic [IDX_W-1:0]        rd_idx,
   output logic signed [ACC_W-1:0] rd_total
);
   logic signed [ACC_W-1:0] tot_q [NUM_BINS];
   logic signed [ACC_W-1:0] act_ext;

   assign act_ext = ACC_W'(add_act);

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      logic hit;
      assign hit = (add_idx == IDX_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tot_q[b] <= '0;
         else if (add_en) begin
            if (clr)
               tot_q[b] <= hit ? act_ext : '0;
            else if (hit)
               tot_q[b] <= tot_q[b] + act_ext;
         end
      end
   end

   assign rd_total = tot_q[rd_idx];
endmodule

// File: rtl/bin_product_stage.sv
module bin_product_stage #(
   parameter int ACC_W = 24,
   parameter int WGT_W = 8,
   parameter int RES_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    step,
   input  logic signed [ACC_W-1:0] bin_total,
   input  logic signed [WGT_W-1:0] bin_wgt,
   output logic signed [RES_W-1:0] sum_next
);
   logic signed [RES_W-1:0] sum_q;
   logic signed [RES_W-1:0] prod;

   assign prod     = RES_W'(bin_total) * RES_W'(bin_wgt);
   assign sum_next = sum_q + prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sum_q <= '0;
      else if (clr)
         sum_q <= '0;
      else if (step)
         sum_q <= sum_next;
   end
endmodule

// File: rtl/binned_mac.sv
module binned_mac #(
   parameter int NUM_BINS = 16,
   parameter int ACT_W    = 8,
   parameter int WGT_W    = 8,
   parameter int ACC_W    = 24,
   parameter int RES_W    = 32,
   localparam int IDX_W   = $clog2(NUM_BINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [ACT_W-1:0] in_act,
   input  logic [IDX_W-1:0] in_idx,
   input  logic             in_start,
   input  logic             in_last,
   input  logic             wt_we,
   input  logic [IDX_W-1:0] wt_addr,
   input  logic [WGT_W-1:0] wt_data,
   output logic [RES_W-1:0] res_data,
   output logic             res_done
);
   import binned_mac_pkg::*;

   localparam logic [IDX_W-1:0] LAST_BIN = IDX_W'(NUM_BINS - 1);

   if (NUM_BINS < 2 || NUM_BINS != (1 << IDX_W)) begin : g_chk_bins
      $error("NUM_BINS must be a power of two of at least 2");
   end
   if (ACC_W <= ACT_W) begin : g_chk_acc
      $error("ACC_W must exceed ACT_W");
   end
   if (RES_W < ACC_W + WGT_W) begin : g_chk_res
      $error("RES_W must hold a full bin product");
   end

   phase_t                  phase_q;
   logic [IDX_W-1:0]        bin_q;
   logic                    done_q;
   logic [RES_W-1:0]        res_q;
   logic                    take;
   logic                    close;
   logic                    final_step;
   logic signed [ACC_W-1:0] cur_total;
   logic signed [WGT_W-1:0] cur_wgt;
   logic signed [RES_W-1:0] sum_next;

   assign in_ready   = (phase_q == PH_ACC);
   assign take       = in_valid && in_ready;
   assign close      = take && in_last;
   assign final_step = (phase_q == PH_MUL) && (bin_q == LAST_BIN);

   bin_accum_bank #(
      .NUM_BINS(NUM_BINS), .ACT_W(ACT_W), .ACC_W(ACC_W)
   ) i_bank (
      .clk(clk), .rst_n(rst_n), .add_en(take), .clr(in_start),
      .add_idx(in_idx), .add_act(in_act), .rd_idx(bin_q), .rd_total(cur_total)
   );

   bin_weight_table #(
      .NUM_BINS(NUM_BINS), .WGT_W(WGT_W)
   ) i_table (
      .clk(clk), .rst_n(rst_n), .wr_en(wt_we && in_ready),
      .wr_idx(wt_addr), .wr_val(wt_data), .rd_idx(bin_q), .rd_val(cur_wgt)
   );

   bin_product_stage #(
      .ACC_W(ACC_W), .WGT_W(WGT_W), .RES_W(RES_W)
   ) i_prod (
      .clk(clk), .rst_n(rst_n), .clr(close), .step(phase_q == PH_MUL),
      .bin_total(cur_total), .bin_wgt(cur_wgt), .sum_next(sum_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_ACC;
         bin_q   <= '0;
         done_q  <= 1'b0;
         res_q   <= '0;
      end else begin
         done_q <= final_step;
         if (close) begin
            phase_q <= PH_MUL;
            bin_q   <= '0;
         end else if (phase_q == PH_MUL) begin
            bin_q <= bin_q + 1'b1;
            if (final_step) begin
               phase_q <= PH_ACC;
               res_q   <= sum_next;
            end
         end
      end
   end

   assign res_data = res_q;
   assign res_done = done_q;
endmodule

// File: rtl/binned_mac_chk.sv
module binned_mac_chk #(
   parameter int NUM_BINS = 16,
   parameter int RES_W    = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_last,
   input logic [RES_W-1:0] res_data,
   input logic             res_done
);
   localparam int CW = $clog2(NUM_BINS + 2) + 1;
   logic [CW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_q <= '0;
      else if (in_valid && in_ready && in_last)
         wait_q <= CW'(1);
      else if (res_done)
         wait_q <= '0;
      else if (wait_q != '0)
         wait_q <= wait_q + 1'b1;
   end

   assert_ready_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);
   assert_ready_held_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_q != '0 && !res_done) |-> !in_ready);
   assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |-> (wait_q == CW'(NUM_BINS + 1)));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_done |=> !res_done);
   assert_result_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !res_done |-> $stable(res_data));
endmodule

bind binned_mac binned_mac_chk #(.NUM_BINS(NUM_BINS), .RES_W(RES_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_last(in_last), .res_data(res_data), .res_done(res_done)
);

// File: tb/test_binned_mac.sv
`timescale 1ns/1ps
module test_binned_mac;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] in_act = '0;
   logic [3:0] in_idx = '0;
   logic       in_start = 1'b0;
   logic       in_last = 1'b0;
   logic       wt_we = 1'b0;
   logic [3:0] wt_addr = '0;
   logic [7:0] wt_data = '0;
   logic [31:0] res_data;
   logic       res_done;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int wgt [16];

   always #2.5 clk = ~clk;

   binned_mac i_binned_mac (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_act(in_act), .in_idx(in_idx), .in_start(in_start), .in_last(in_last),
      .wt_we(wt_we), .wt_addr(wt_addr), .wt_data(wt_data),
      .res_data(res_data), .res_done(res_done)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic put_wgt(input int b, input int v);
      @(negedge clk);
      wt_we = 1'b1; wt_addr = 4'(b); wt_data = 8'(v);
      @(posedge clk);
      @(negedge clk);
      wt_we = 1'b0;
      wgt[b] = v;
   endtask

   task automatic beat(input int idx, input int act, input bit st, input bit lst);
      @(negedge clk);
      in_valid = 1'b1; in_idx = 4'(idx); in_act = 8'(act);
      in_start = st; in_last = lst;
      @(posedge clk);
   endtask

   task automatic gap();
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk);
   endtask

   task automatic finish_run(input longint exp, input string tag, input bit poke);
      int n = 0;
      int busy_bad = 0;
      while (n < 40) begin
         @(negedge clk);
         n++;
         in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
         if (poke && n == 3) begin
            wt_we = 1'b1; wt_addr = 4'd5; wt_data = 8'd99;
         end
         if (poke && n == 4) wt_we = 1'b0;
         if (res_done) break;
         if (in_ready) busy_bad++;
      end
      chk(busy_bad == 0, "R4 in_ready low in multiply phase", busy_bad, 0);
      chk(n == 17, "R5 done latency in falling edges", n, 17);
      chk(longint'($signed(res_data)) == exp, tag, longint'($signed(res_data)), exp);
      @(negedge clk);
      chk(res_done == 1'b0, "R6 done single pulse", res_done, 0);
      chk(longint'($signed(res_data)) == exp, "R6 result holds", longint'($signed(res_data)), exp);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      longint exp;
      int acts [5] = '{-128, -1, 0, 1, 127};
      for (int b = 0; b < 16; b++) wgt[b] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
      chk(res_done == 1'b0, "R1 done after reset", res_done, 0);
      chk(res_data == 32'd0, "R1 result after reset", res_data, 0);

      // R9: weights still zero, so any stream gives zero
      beat(3, 100, 1'b1, 1'b0);
      beat(9, -50, 1'b0, 1'b1);
      finish_run(0, "R9 zero weights after reset", 1'b0);

      for (int b = 0; b < 16; b++) put_wgt(b, b * 9 - 70);

      // R2/R8: every bin against boundary activations, single beat
      for (int b = 0; b < 16; b++) begin
         for (int k = 0; k < 5; k++) begin
            beat(b, acts[k], 1'b1, 1'b1);
            finish_run(longint'(acts[k]) * wgt[b], "R2 single bin product", 1'b0);
         end
      end

      // R8: long stream with gaps, bin 11 left empty; weight write during multiply (R7)
      exp = 0;
      for (int i = 0; i < 200; i++) begin
         int idx = (i * 7 + 3) % 16;
         int a = ((i * 37) % 256) - 128;
         if (idx == 11) idx = 12;
         if (i % 5 == 4) gap();
         beat(idx, a, i == 0, i == 199);
         exp += longint'(a) * wgt[idx];
      end
      finish_run(exp, "R8 long stream dot product", 1'b1);
      beat(5, 1, 1'b1, 1'b1);
      finish_run(wgt[5], "R7 write during multiply ignored", 1'b0);

      // R7: write while accumulating is taken
      put_wgt(5, 99);
      beat(5, 2, 1'b1, 1'b1);
      finish_run(198, "R7 write while idle stored", 1'b0);

      // R3: restart mid-stream discards earlier beats
      for (int i = 0; i < 10; i++) beat(2, 100, i == 0, 1'b0);
      beat(4, -3, 1'b1, 1'b0);
      beat(4, 7, 1'b0, 1'b1);
      finish_run(4 * longint'(wgt[4]), "R3 start clears bins", 1'b0);

      // R8: extreme weights and activations
      put_wgt(0, -128);
      put_wgt(15, 127);
      exp = 0;
      for (int i = 0; i < 300; i++) begin
         if (i % 2 == 0) begin
            beat(0, -128, i == 0, 1'b0);
            exp += -128 * -128;
         end else begin
            beat(15, 127, 1'b0, i == 299);
            exp += 127 * 127;
         end
      end
      finish_run(exp, "R8 extreme values", 1'b0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule